// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a single carry input, and it returns their sum together with a carry output. For each bit it forms a generate term and a propagate term. Inside every fixed-width group of bits, each internal carry is written as one flat sum of products over the group's lower generate and propagate terms and the group's incoming carry. The carry therefore never steps from bit to bit inside a group.

The groups are then linked in a chain. The carry leaving one group is the carry entering the next. This keeps each lookahead cell small and uniform, while the carry still settles faster than it would through a plain bit-serial chain. The default build is 32 bits wide, made of eight 4-bit groups. It is meant for datapaths that need the exact value of a+b+cin with no added state.

Top module: `cla_chain_adder`

## Requirements
- R1: For each bit position, the generate term is high exactly when both operand bits are 1, and then a carry leaves that bit whatever the incoming carry is.
- R2: For each bit position, the propagate term is high when either operand bit is 1. A propagating bit whose generate term is low passes the incoming carry on unchanged.
- R3: Each carry inside a group equals the generate term of the bit below it, OR that bit's propagate term AND the carry into that bit.
- R4: Each internal carry of a group is formed as a single two-level AND-OR expression. Its inputs are the group's lower generate terms, its lower propagate terms and the group's carry-in, and no earlier internal carry is used.
- R5: Each sum bit is the XOR of the two operand bits and the carry into that bit position.
- R6: The operands are split into groups of GROUP_W bits (default 4, giving eight groups). Group 0 takes `carry_in`, and each higher group takes the carry-out of the group directly below it, so a carry crosses the bit 3/4 boundary and every other group boundary.
- R7: `carry_out` is the carry leaving the most significant group, which is bit 32 of the true sum.
- R8: The concatenation {`carry_out`, `sum`} equals `op_a` + `op_b` + `carry_in` exactly for every operand value. This includes the case where a carry entering at bit 0 travels through all groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of op_a + op_b + carry_in |
| carry_out | output | 1 | Carry out of the top group |

## Verification
The assertions are re-evaluated whenever the inputs change. They check that every internal carry of the flat product terms agrees with the bitwise recurrence, that generate implies propagate, that each group's result equals its own small addition, and that the full result equals the wide sum. Assertions cannot show which inputs actually drive a long carry across every group boundary. The bench's directed patterns supply those cases: all-propagate operands with a carry-in, carries that cross a single boundary, and a carry produced only in the top bit. Random operands then cover the rest of the value space against a bit-serial reference model.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Bitwise generate: a carry is produced regardless of incoming carry.
  function automatic logic gen_bit(input logic x, input logic y);
    return x & y;
  endfunction

  // Bitwise propagate: an incoming carry can pass through.
  function automatic logic prop_bit(input logic x, input logic y);
    return x | y;
  endfunction

  // Sum bit from operand bits and carry into the position.
  function automatic logic sum_bit(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell
  import cla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = gen_bit(a[i], b[i]);
    assign p[i] = prop_bit(a[i], b[i]);
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      AST_GEN_IMPLIES_PROP: assert (!g[i] || p[i]) else $error("generate without propagate at bit %0d", i); // R1
      AST_PROP_MATCH: assert (p[i] == (a[i] | b[i])) else $error("propagate mismatch at bit %0d", i); // R2
    end
  end

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W:0]   carry
);

  logic [W:0] carry_sop;

  // Each carry is a flat OR of AND terms over lower g/p and cin (R4).
  always_comb begin
    logic acc;
    logic prod;
    carry_sop[0] = cin;
    for (int i = 0; i < W; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = g[j];
        for (int k = j + 1; k <= i; k++) prod = prod & p[k];
        acc = acc | prod;
      end
      prod = cin;
      for (int k = 0; k <= i; k++) prod = prod & p[k];
      carry_sop[i+1] = acc | prod;
    end
  end

  assign carry = carry_sop;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      AST_CARRY_RECUR: assert (carry[i+1] == (g[i] | (p[i] & carry[i]))) else $error("carry recurrence broken at %0d", i); // R3
    end
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W-1:0] g_w;
  logic [W-1:0] p_w;
  logic [W:0]   c_w;

  cla_pg_cell #(.W(W)) u_pg (.a(a), .b(b), .g(g_w), .p(p_w));
  cla_lookahead #(.W(W)) u_la (.g(g_w), .p(p_w), .cin(cin), .carry(c_w));

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign s[i] = sum_bit(a[i], b[i], c_w[i]);
  end
  assign cout = c_w[W];

  always_comb begin
    AST_GROUP_SUM: assert ({cout, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})) else $error("group sum mismatch"); // R5
  end

endmodule

// File: rtl/cla_chain_adder.sv
module cla_chain_adder #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  localparam int NGROUPS = WIDTH / GROUP_W;

  logic [NGROUPS:0] grp_c;

  assign grp_c[0] = carry_in;

  for (genvar gi = 0; gi < NGROUPS; gi++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .a   (op_a[gi*GROUP_W +: GROUP_W]),
      .b   (op_b[gi*GROUP_W +: GROUP_W]),
      .cin (grp_c[gi]),
      .s   (sum[gi*GROUP_W +: GROUP_W]),
      .cout(grp_c[gi+1])
    );
  end

  assign carry_out = grp_c[NGROUPS];

  always_comb begin
    AST_WIDE_SUM: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})) else $error("wide sum mismatch"); // R8
    AST_TOP_CARRY: assert (carry_out == ((op_a[WIDTH-1] & op_b[WIDTH-1]) | ((op_a[WIDTH-1] ^ op_b[WIDTH-1]) & ~sum[WIDTH-1]))) else $error("carry out mismatch"); // R7
  end

endmodule

// File: tb/tb_cla_chain_adder.sv
module tb_cla_chain_adder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [31:0] sum;
  logic        carry_out;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cla_chain_adder dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  // Bit-serial reference: walk bits low to high.
  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y, input logic c0);
    logic [32:0] r;
    logic c;
    c = c0;
    for (int i = 0; i < 32; i++) begin
      r[i] = (x[i] + y[i] + c) % 2;
      c = ((x[i] + y[i] + c) >= 2);
    end
    r[32] = c;
    return r;
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic c0, input string req);
    logic [32:0] exp;
    @(negedge clk);
    op_a = x; op_b = y; carry_in = c0;
    #1;
    exp = ref_add(x, y, c0);
    checks++;
    if ({carry_out, sum} !== exp) begin
      failures++;
      $display("FAIL %s: a=%h b=%h cin=%b got=%h expected=%h", req, x, y, c0, {carry_out, sum}, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(32'h0, 32'h0, 1'b0, "R8 reset-state zero");
    apply(32'h1, 32'h1, 1'b0, "R1 generate");
    apply(32'h0000_0005, 32'h0000_000A, 1'b1, "R2 propagate");
    apply(32'h0000_0003, 32'h0000_0001, 1'b0, "R3 carry chain in group");
    apply(32'h0000_0007, 32'h0000_0000, 1'b1, "R4 cin to bit 3");
    apply(32'h0000_0006, 32'h0000_0003, 1'b0, "R5 sum xor");
    apply(32'h0000_000F, 32'h0000_0001, 1'b0, "R6 boundary 3/4");
    apply(32'h0000_00F0, 32'h0000_0010, 1'b0, "R6 boundary 7/8");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 top carry");
    apply(32'hF000_0000, 32'h1000_0000, 1'b0, "R7 top group carry");
    apply(32'hFFFF_FFFF, 32'h0, 1'b1, "R8 full propagate");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 all ones");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R8 alternating");
    void'($urandom(32'd1234));
    for (int n = 0; n < 2000; n++) begin
      apply($urandom, $urandom, 1'($urandom), "R8 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule